// File: doc/BRIEF.md
# Indexed configuration register port

This block holds a small bank of byte-wide configuration registers and reaches them through two I/O byte addresses. Software writes an index to the index port at 0x22. It then makes one read or one write at the data port at 0x23, and that access goes to the register the index selects. The bank covers the indices 0x30 to 0x3F.

The register at index 0x3F is the control register. Bit 4 of that register is a mapping-enable bit. While the bit is clear, every other register in the bank is hidden: reads of it return 0xFF and writes to it are lost. The control register can always be reached, so software can read the control register, set the mapping-enable bit, do its accesses and then write the old value back.

The register at index 0x38 holds the graphics setting. Its two lowest bits drive bits 31:30 of the graphics base address output, and all lower address bits are zero.

Top module: `cfg_index_port`

## Requirements
- R1: A write at I/O address 0x22 latches the byte as the index. The next access at I/O address 0x23 reads or writes the register at that index.
- R2: A latched index serves one data-port access only, whether a read or a write. A second data-port access with no new index write in between is dropped if it is a write, and returns 0xFF if it is a read.
- R3: The control register at index 0x3F can be read and written at any time, whatever the state of its mapping-enable bit (bit 4).
- R4: While bit 4 of the control register is 0, a data-port read of any other index in the bank returns 0xFF, and a data-port write to such an index leaves the register unchanged.
- R5: The output gfx_base is {reg 0x38 bits [1:0], 30 zero bits}. It changes only after a successful write to index 0x38.
- R6: After reset every register is 0, mapping is disabled, gfx_base is 0 and no index is latched.
- R7: An index outside the range 0x30 to 0x3F reads as 0xFF, and a write to it changes nothing.
- R8: Read data appears on io_rdata in the same cycle as the read strobe, and io_rdata is 0xFF when no granted read is in progress. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| gfx_base | output | 32 | Decoded graphics base address |

## Verification
The index latch is the state that can go wrong without any sign at the ports. If the valid flag is stuck high, the second data read in a row returns real data instead of 0xFF. If the latched index is wrong, the register read back in the cycle just after the write holds another value. A fault in the mapping gate shows at once as a hidden register that reads back real data, or as a lost write that later reads back as 0. A fault in the base decode shows on gfx_base one edge after the graphics register is written.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef logic [7:0] byte_t;

  // True when idx falls in [base, base+n)
  function automatic logic in_window(input byte_t idx, input byte_t base, input int unsigned n);
    return (32'(idx) >= 32'(base)) && (32'(idx) < 32'(base) + n);
  endfunction

  // Graphics base: two select bits placed at the top of a 32-bit address
  function automatic logic [31:0] base_from_cfg(input byte_t cfg);
    return {cfg[1:0], 30'b0};
  endfunction
endpackage

// File: rtl/cfgp_index_latch.sv
module cfgp_index_latch
  import cfgp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_wr,
  input  byte_t wdata,
  input  logic  data_acc,
  output byte_t idx_q,
  output logic  idx_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      idx_valid <= 1'b0;
    end else if (idx_wr) begin
      idx_q     <= wdata;
      idx_valid <= 1'b1;
    end else if (data_acc) begin
      idx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgp_access_gate.sv
module cfgp_access_gate
  import cfgp_pkg::*;
#(
  parameter byte_t       WIN_BASE = 8'h30,
  parameter int unsigned NUM_REGS = 16,
  parameter byte_t       CTRL_IDX = 8'h3F,
  localparam int         SLOT_W   = $clog2(NUM_REGS)
) (
  input  byte_t             idx,
  input  logic              idx_valid,
  input  logic              map_en,
  output logic              grant,
  output logic [SLOT_W-1:0] slot
);
  byte_t diff;
  logic  in_win;
  logic  always_open;

  assign diff        = idx - WIN_BASE;
  assign slot        = diff[SLOT_W-1:0];
  assign in_win      = in_window(idx, WIN_BASE, NUM_REGS);
  assign always_open = (idx == CTRL_IDX);
  assign grant       = idx_valid && in_win && (always_open || map_en);
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
  import cfgp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  localparam int         SLOT_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  byte_t             wdata,
  output byte_t             rdata,
  output byte_t             regs_o [NUM_REGS]
);
  for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_o[i] <= '0;
      else if (we && slot == SLOT_W'(i))
        regs_o[i] <= wdata;
    end
  end

  assign rdata = regs_o[slot];
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter byte_t       WIN_BASE  = 8'h30,
  parameter int unsigned NUM_REGS  = 16,
  parameter byte_t       CTRL_IDX  = 8'h3F,
  parameter int          MAP_BIT   = 4,
  parameter byte_t       GFX_IDX   = 8'h38
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [31:0] gfx_base
);
  localparam int SLOT_W    = $clog2(NUM_REGS);
  localparam int CTRL_SLOT = int'(CTRL_IDX) - int'(WIN_BASE);
  localparam int GFX_SLOT  = int'(GFX_IDX) - int'(WIN_BASE);

  // named events
  logic idx_wr, data_wr, data_rd, data_acc;
  logic idx_valid, grant, map_en, reg_we;
  byte_t idx_q, reg_rdata;
  logic [SLOT_W-1:0] slot;
  byte_t regs [NUM_REGS];

  assign idx_wr   = io_wr && (io_addr == IDX_PORT);
  assign data_wr  = io_wr && (io_addr == DATA_PORT);
  assign data_rd  = io_rd && (io_addr == DATA_PORT);
  assign data_acc = data_wr || data_rd;

  cfgp_index_latch u_idx (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .data_acc(data_acc), .idx_q(idx_q), .idx_valid(idx_valid)
  );

  cfgp_access_gate #(.WIN_BASE(WIN_BASE), .NUM_REGS(NUM_REGS), .CTRL_IDX(CTRL_IDX)) u_gate (
    .idx(idx_q), .idx_valid(idx_valid), .map_en(map_en), .grant(grant), .slot(slot)
  );

  assign reg_we = data_wr && grant;

  cfgp_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .slot(slot), .wdata(io_wdata),
    .rdata(reg_rdata), .regs_o(regs)
  );

  assign map_en   = regs[CTRL_SLOT][MAP_BIT];
  assign gfx_base = base_from_cfg(regs[GFX_SLOT]);
  assign io_rdata = (data_rd && grant) ? reg_rdata : 8'hFF;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter logic [7:0] CTRL_IDX = 8'h3F,
  parameter int         MAP_BIT  = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic [31:0] gfx_base,
  input logic        idx_wr,
  input logic        data_wr,
  input logic        data_rd,
  input logic        data_acc,
  input logic        idx_valid,
  input logic [7:0]  idx_q,
  input logic        map_en
);
  // R2
  idx_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !idx_wr) |=> !idx_valid);
  // R2
  stale_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !idx_valid) |-> io_rdata == 8'hFF);
  // R4
  gated_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx_valid && !map_en && idx_q != CTRL_IDX) |-> io_rdata == 8'hFF);
  // R5
  base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_base[29:0] == 30'd0);
  // R5
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(gfx_base));
  // R3
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_valid && idx_q == CTRL_IDX) |=> map_en == $past(io_wdata[MAP_BIT]));
endmodule

bind cfg_index_port cfgp_chk #(.CTRL_IDX(CTRL_IDX), .MAP_BIT(MAP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .gfx_base(gfx_base), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
  .data_acc(data_acc), .idx_valid(idx_valid), .idx_q(idx_q), .map_en(map_en)
);

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [31:0] gfx_base;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [15:0] IP = 16'h0022, DP = 16'h0023;

  always #4 clk = ~clk;

  cfg_index_port u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .gfx_base(gfx_base));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    wr(IP, idx); wr(DP, d);
  endtask

  task automatic get_reg(input logic [7:0] idx, output logic [7:0] d);
    wr(IP, idx); rd(DP, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R6 base", gfx_base, 32'h0);
    #1 chk("R8 idle rdata", {24'h0, io_rdata}, 32'hFF);
    rd(DP, v); chk("R6 no index", {24'h0, v}, 32'hFF);
    get_reg(8'h3F, v); chk("R6 ctrl zero", {24'h0, v}, 32'h00);
    get_reg(8'h31, v); chk("R6 gated at reset", {24'h0, v}, 32'hFF);
  endtask

  task automatic t_ctrl_gate;
    logic [7:0] v;
    set_reg(8'h31, 8'h5A);           // dropped: map off
    set_reg(8'h3F, 8'h10);           // map on
    get_reg(8'h3F, v); chk("R3 ctrl readback", {24'h0, v}, 32'h10);
    get_reg(8'h31, v); chk("R4 write dropped", {24'h0, v}, 32'h00);
    set_reg(8'h31, 8'h5A);
    get_reg(8'h31, v); chk("R1 write/read", {24'h0, v}, 32'h5A);
    set_reg(8'h3F, 8'h00);           // map off
    get_reg(8'h31, v); chk("R4 hidden read", {24'h0, v}, 32'hFF);
    set_reg(8'h3F, 8'h10);
    get_reg(8'h31, v); chk("R1 value kept", {24'h0, v}, 32'h5A);
  endtask

  task automatic t_oneshot;
    logic [7:0] v;
    set_reg(8'h32, 8'h11);
    wr(DP, 8'h22);                   // no new index: dropped
    get_reg(8'h32, v); chk("R2 second write dropped", {24'h0, v}, 32'h11);
    rd(DP, v); chk("R2 second read FF", {24'h0, v}, 32'hFF);
  endtask

  task automatic t_base;
    logic [7:0] v;
    wr(IP, 8'h38);
    @(negedge clk); io_addr = DP; io_wdata = 8'hFE; io_wr = 1'b1;
    #1 chk("R8 before edge", gfx_base, 32'h0);
    @(posedge clk); #1 chk("R5 base 2", gfx_base, 32'h8000_0000);
    @(negedge clk); io_wr = 1'b0;
    set_reg(8'h38, 8'h03); chk("R5 base 3", gfx_base, 32'hC000_0000);
    set_reg(8'h3F, 8'h00);
    set_reg(8'h38, 8'h01); chk("R4 base unchanged", gfx_base, 32'hC000_0000);
    set_reg(8'h3F, 8'h10);
    get_reg(8'h38, v); chk("R5 reg value", {24'h0, v}, 32'h03);
  endtask

  task automatic t_window;
    logic [7:0] v;
    set_reg(8'h10, 8'h77);
    get_reg(8'h10, v); chk("R7 below window", {24'h0, v}, 32'hFF);
    get_reg(8'h40, v); chk("R7 above window", {24'h0, v}, 32'hFF);
    get_reg(8'h31, v); chk("R7 bank intact", {24'h0, v}, 32'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl_gate;
    t_oneshot;
    t_base;
    t_window;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule